// File: doc/BRIEF.md
# Four-Pass Broadcast Multiply-Accumulate Sequencer

This controller steps a 16-lane single-precision vector unit through one chained multiply-accumulate operation of four passes. A start pulse supplies the parameters: a base source-register number, a memory base address, a negate flag, a packed or scalar selection, a 16-bit write mask, a merge or zero masking selection, and the current destination vector. In each pass the controller reads one source vector from the register file and one 32-bit multiplier from memory. It copies that multiplier into every lane and hands multiplicand, multiplier and running accumulator to an external per-lane fused multiply-add unit.

The arithmetic unit rounds every pass, so the block keeps a running accumulator and does no arithmetic of its own. Across the passes the register number cycles through its aligned group of four, and the memory address moves up one 32-bit word per pass. After the fourth result the controller applies the write mask, writes the destination vector back once and pulses done.

Top module: `quad_mac_seq`

## Requirements
- R1: Every accepted start produces exactly four register reads, four memory reads, four arithmetic requests and one write-back.
- R2: The register index of pass p (0..3) keeps the upper bits of the base number and uses (base low two bits + p) mod 4 as its low two bits. Base 12 reads 12, 13, 14, 15 and base 13 reads 13, 14, 15, 12.
- R3: The memory address of pass p is the base address plus 4*p.
- R4: Each arithmetic request carries the word read from memory in all 16 lanes of the multiplier vector, together with the source vector as multiplicand.
- R5: `fma_neg` equals the negate flag latched at start for all four requests. The bench's stand-in arithmetic subtracts the product when it is set.
- R6: The accumulator starts from `dst_in`, and the result of each pass becomes the accumulator operand of the next. The final write-back therefore reflects all four rounded results.
- R7: In packed merge mode (`zero_mode`=0), lane i of the write-back is the accumulated value when `wmask[i]`=1 and the `dst_in` value otherwise.
- R8: In packed zero mode (`zero_mode`=1), lanes with a clear mask bit are written as 0.
- R9: In scalar mode `fma_lane_en` is 0x0001 and only lane 0 of each result is accumulated. Lane 0 of the write-back is masked by `wmask[0]` only. Lanes 1 to 3 keep `dst_in`, and lanes 4 to 15 (bits 511:128) are 0.
- R10: A request is held, with stable operands, until `fma_req_ready` is high. A pass does not advance until `fma_rsp_valid` is seen.
- R11: `done` is high for exactly one cycle, in the cycle after `wb_en`, and `busy` is low from that cycle on.
- R12: A start pulse while `busy` is high has no effect on reads, requests or the written result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| base_reg | input | 5 | First source-register number |
| mem_base | input | 32 | Byte address of the first multiplier |
| negate | input | 1 | Negate every product |
| scalar_mode | input | 1 | 1 = lane 0 only, 0 = all lanes |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = keep them |
| wmask | input | 16 | Per-lane write mask |
| dst_in | input | 512 | Destination vector before the operation |
| busy | output | 1 | Operation in progress |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_idx | output | 5 | Register number to read |
| rf_rd_data | input | 512 | Read data, valid the cycle after the strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Byte address to read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| fma_req_valid | output | 1 | Arithmetic request valid |
| fma_req_ready | input | 1 | Arithmetic unit takes the request |
| fma_a | output | 512 | Multiplicand vector |
| fma_b | output | 512 | Broadcast multiplier vector |
| fma_c | output | 512 | Accumulator vector |
| fma_neg | output | 1 | Negate the products |
| fma_lane_en | output | 16 | Lanes to compute |
| fma_rsp_valid | input | 1 | Result valid |
| fma_rsp_data | input | 512 | Per-lane rounded results |
| wb_en | output | 1 | Destination write strobe |
| wb_data | output | 512 | Masked destination vector |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume a memory and register file that answer one cycle after the strobe. They also assume an arithmetic unit that raises its result at least one cycle after it accepts a request and never answers without a request. The group and step properties rely on start parameters captured only while the block is idle. The bench models both memories with one-cycle registered reads. Its arithmetic stand-in takes a request under a changing ready pattern and answers one to three cycles later. It pulses start only when idle, except in the case that deliberately fires a second start during a busy run.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAP,
    ST_ISSUE,
    ST_WAIT,
    ST_WB,
    ST_DONE
  } qmac_state_e;
endpackage

// File: rtl/qmac_step.sv
// Operand locator: register number wraps in its aligned group, address steps by one word
module qmac_step #(
  parameter int RIDX_W = 5,
  parameter int ADDR_W = 32,
  parameter int PASSES = 4,
  parameter int STEP   = 4,
  localparam int PW    = $clog2(PASSES)
) (
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PW-1:0]     pass,
  output logic [RIDX_W-1:0] idx,
  output logic [ADDR_W-1:0] addr
);
  logic [PW-1:0] low_sum;
  assign low_sum = base_idx[PW-1:0] + pass;
  assign idx     = {base_idx[RIDX_W-1:PW], low_sum};
  assign addr    = base_addr + ADDR_W'(pass) * ADDR_W'(STEP);
endmodule

// File: rtl/qmac_bcast.sv
// Copy one element into every lane
module qmac_bcast #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32
) (
  input  logic [ELEM_W-1:0]       elem,
  output logic [LANES*ELEM_W-1:0] vec
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vec[l*ELEM_W +: ELEM_W] = elem;
  end
endmodule

// File: rtl/qmac_merge.sv
// Final write-back lane selection under mask and mode
module qmac_merge #(
  parameter int LANES      = 16,
  parameter int ELEM_W     = 32,
  parameter int KEEP_LANES = 4
) (
  input  logic [LANES*ELEM_W-1:0] acc,
  input  logic [LANES*ELEM_W-1:0] old,
  input  logic [LANES-1:0]        mask,
  input  logic                    zero_mode,
  input  logic                    scalar,
  output logic [LANES*ELEM_W-1:0] out
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] masked;
    assign masked = mask[l] ? acc[l*ELEM_W +: ELEM_W]
                  : (zero_mode ? '0 : old[l*ELEM_W +: ELEM_W]);
    if (l == 0) begin : g_first
      assign out[l*ELEM_W +: ELEM_W] = masked;
    end else if (l < KEEP_LANES) begin : g_low
      assign out[l*ELEM_W +: ELEM_W] = scalar ? old[l*ELEM_W +: ELEM_W] : masked;
    end else begin : g_high
      assign out[l*ELEM_W +: ELEM_W] = scalar ? '0 : masked;
    end
  end
endmodule

// File: rtl/quad_mac_seq.sv
module quad_mac_seq
  import qmac_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ELEM_W     = 32,
  parameter int RIDX_W     = 5,
  parameter int ADDR_W     = 32,
  parameter int PASSES     = 4,
  parameter int KEEP_LANES = 4,
  localparam int VEC_W     = LANES * ELEM_W,
  localparam int PW        = $clog2(PASSES),
  localparam int STEP      = ELEM_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RIDX_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic              negate,
  input  logic              scalar_mode,
  input  logic              zero_mode,
  input  logic [LANES-1:0]  wmask,
  input  logic [VEC_W-1:0]  dst_in,
  output logic              busy,
  output logic              rf_rd_en,
  output logic [RIDX_W-1:0] rf_rd_idx,
  input  logic [VEC_W-1:0]  rf_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [ELEM_W-1:0] mem_rd_data,
  output logic              fma_req_valid,
  input  logic              fma_req_ready,
  output logic [VEC_W-1:0]  fma_a,
  output logic [VEC_W-1:0]  fma_b,
  output logic [VEC_W-1:0]  fma_c,
  output logic              fma_neg,
  output logic [LANES-1:0]  fma_lane_en,
  input  logic              fma_rsp_valid,
  input  logic [VEC_W-1:0]  fma_rsp_data,
  output logic              wb_en,
  output logic [VEC_W-1:0]  wb_data,
  output logic              done
);
  localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

  qmac_state_e       state;
  logic [PW-1:0]     pass_q;
  logic [PW-1:0]     pass_nx;
  logic [RIDX_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sc_q;
  logic              zm_q;
  logic [LANES-1:0]  mask_q;
  logic [VEC_W-1:0]  old_q;
  logic [VEC_W-1:0]  acc_q;
  logic [RIDX_W-1:0] nx_idx;
  logic [ADDR_W-1:0] nx_addr;
  logic [VEC_W-1:0]  bvec;
  logic [VEC_W-1:0]  wb_vec;

  assign pass_nx = pass_q + 1'b1;

  qmac_step #(.RIDX_W(RIDX_W), .ADDR_W(ADDR_W), .PASSES(PASSES), .STEP(STEP)) u_step (
    .base_idx (base_q),
    .base_addr(addr_q),
    .pass     (pass_nx),
    .idx      (nx_idx),
    .addr     (nx_addr)
  );

  qmac_bcast #(.LANES(LANES), .ELEM_W(ELEM_W)) u_bcast (
    .elem(mem_rd_data),
    .vec (bvec)
  );

  qmac_merge #(.LANES(LANES), .ELEM_W(ELEM_W), .KEEP_LANES(KEEP_LANES)) u_merge (
    .acc      (acc_q),
    .old      (old_q),
    .mask     (mask_q),
    .zero_mode(zm_q),
    .scalar   (sc_q),
    .out      (wb_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pass_q        <= '0;
      base_q        <= '0;
      addr_q        <= '0;
      sc_q          <= 1'b0;
      zm_q          <= 1'b0;
      mask_q        <= '0;
      old_q         <= '0;
      acc_q         <= '0;
      busy          <= 1'b0;
      rf_rd_en      <= 1'b0;
      rf_rd_idx     <= '0;
      mem_rd_en     <= 1'b0;
      mem_rd_addr   <= '0;
      fma_req_valid <= 1'b0;
      fma_a         <= '0;
      fma_b         <= '0;
      fma_c         <= '0;
      fma_neg       <= 1'b0;
      fma_lane_en   <= '0;
      wb_en         <= 1'b0;
      wb_data       <= '0;
      done          <= 1'b0;
    end else begin
      rf_rd_en  <= 1'b0;
      mem_rd_en <= 1'b0;
      wb_en     <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          base_q      <= base_reg;
          addr_q      <= mem_base;
          sc_q        <= scalar_mode;
          zm_q        <= zero_mode;
          mask_q      <= wmask;
          old_q       <= dst_in;
          acc_q       <= dst_in;
          pass_q      <= '0;
          fma_neg     <= negate;
          fma_lane_en <= scalar_mode ? LANES'(1) : '1;
          rf_rd_en    <= 1'b1;
          rf_rd_idx   <= base_reg;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= mem_base;
          busy        <= 1'b1;
          state       <= ST_REQ;
        end
        ST_REQ: state <= ST_CAP;
        ST_CAP: begin
          fma_a         <= rf_rd_data;
          fma_b         <= bvec;
          fma_c         <= acc_q;
          fma_req_valid <= 1'b1;
          state         <= ST_ISSUE;
        end
        ST_ISSUE: if (fma_req_ready) begin
          fma_req_valid <= 1'b0;
          state         <= ST_WAIT;
        end
        ST_WAIT: if (fma_rsp_valid) begin
          if (sc_q) acc_q[ELEM_W-1:0] <= fma_rsp_data[ELEM_W-1:0];
          else      acc_q             <= fma_rsp_data;
          if (pass_q == LAST) begin
            state <= ST_WB;
          end else begin
            pass_q      <= pass_nx;
            rf_rd_en    <= 1'b1;
            rf_rd_idx   <= nx_idx;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= nx_addr;
            state       <= ST_REQ;
          end
        end
        ST_WB: begin
          wb_en   <= 1'b1;
          wb_data <= wb_vec;
          state   <= ST_DONE;
        end
        ST_DONE: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qmac_chk.sv
module qmac_chk #(
  parameter int LANES      = 16,
  parameter int ELEM_W     = 32,
  parameter int RIDX_W     = 5,
  parameter int ADDR_W     = 32,
  parameter int PASSES     = 4,
  parameter int KEEP_LANES = 4,
  localparam int VEC_W     = LANES * ELEM_W,
  localparam int PW        = $clog2(PASSES),
  localparam int KEEP_W    = KEEP_LANES * ELEM_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [RIDX_W-1:0] base_reg,
  input logic              scalar_mode,
  input logic              rf_rd_en,
  input logic [RIDX_W-1:0] rf_rd_idx,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              fma_req_valid,
  input logic              fma_req_ready,
  input logic [VEC_W-1:0]  fma_b,
  input logic [LANES-1:0]  fma_lane_en,
  input logic              wb_en,
  input logic [VEC_W-1:0]  wb_data,
  input logic              done
);
  logic [RIDX_W-PW-1:0] grp_c;
  logic                 scal_c;
  logic                 first_c;
  logic [ADDR_W-1:0]    prev_addr_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_c       <= '0;
      scal_c      <= 1'b0;
      first_c     <= 1'b1;
      prev_addr_c <= '0;
    end else begin
      if (start && !busy) begin
        grp_c   <= base_reg[RIDX_W-1:PW];
        scal_c  <= scalar_mode;
        first_c <= 1'b1;
      end else if (mem_rd_en) begin
        first_c <= 1'b0;
      end
      if (mem_rd_en) prev_addr_c <= mem_rd_addr;
    end
  end

  a_r2_same_group: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |-> rf_rd_idx[RIDX_W-1:PW] == grp_c);

  a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !first_c) |-> mem_rd_addr == prev_addr_c + ADDR_W'(ELEM_W / 8));

  a_r4_broadcast: assert property (@(posedge clk) disable iff (rst)
    fma_req_valid |-> fma_b == {LANES{fma_b[ELEM_W-1:0]}});

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (fma_req_valid && !fma_req_ready) |=> (fma_req_valid && $stable(fma_b)));

  a_r9_scalar_lane: assert property (@(posedge clk) disable iff (rst)
    (fma_req_valid && scal_c) |-> fma_lane_en == LANES'(1));

  a_r9_scalar_upper: assert property (@(posedge clk) disable iff (rst)
    (wb_en && scal_c) |-> wb_data[VEC_W-1:KEEP_W] == '0);

  a_r11_done_after_wb: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> (done && !wb_en && !busy));

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind quad_mac_seq qmac_chk #(
  .LANES(LANES), .ELEM_W(ELEM_W), .RIDX_W(RIDX_W), .ADDR_W(ADDR_W),
  .PASSES(PASSES), .KEEP_LANES(KEEP_LANES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .base_reg     (base_reg),
  .scalar_mode  (scalar_mode),
  .rf_rd_en     (rf_rd_en),
  .rf_rd_idx    (rf_rd_idx),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_addr  (mem_rd_addr),
  .fma_req_valid(fma_req_valid),
  .fma_req_ready(fma_req_ready),
  .fma_b        (fma_b),
  .fma_lane_en  (fma_lane_en),
  .wb_en        (wb_en),
  .wb_data      (wb_data),
  .done         (done)
);

// File: tb/quad_mac_seq_test.sv
module quad_mac_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int VW    = LANES * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [4:0]    base_reg = '0;
  logic [31:0]   mem_base = '0;
  logic          negate = 1'b0;
  logic          scalar_mode = 1'b0;
  logic          zero_mode = 1'b0;
  logic [15:0]   wmask = '0;
  logic [VW-1:0] dst_in = '0;
  logic          busy, rf_rd_en, mem_rd_en, fma_req_valid, fma_neg, wb_en, done;
  logic [4:0]    rf_rd_idx;
  logic [31:0]   mem_rd_addr;
  logic [VW-1:0] rf_rd_data = '0;
  logic [31:0]   mem_rd_data = '0;
  logic          fma_req_ready = 1'b0;
  logic [VW-1:0] fma_a, fma_b, fma_c, wb_data;
  logic [15:0]   fma_lane_en;
  logic          fma_rsp_valid = 1'b0;
  logic [VW-1:0] fma_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0]    exp_idx[$];
  logic [31:0]   exp_addr[$];
  logic [VW-1:0] exp_wb[$];
  logic          cur_neg = 1'b0;
  logic          cur_sc = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_mac_seq uut (.*);

  function automatic logic [31:0] rpat(input logic [4:0] idx, input int l);
    return 32'(idx) * 32'd256 + 32'(l) * 32'd3 + 32'd1;
  endfunction
  function automatic logic [31:0] mpat(input logic [31:0] a);
    return (a & 32'hff) + 32'd2;
  endfunction

  // memory and register file stand-ins, one-cycle read latency
  always @(posedge clk) begin
    if (rf_rd_en)
      for (int l = 0; l < LANES; l++) rf_rd_data[l*EW +: EW] <= rpat(rf_rd_idx, l);
    if (mem_rd_en) mem_rd_data <= mpat(mem_rd_addr);
  end

  // arithmetic stand-in: integer c +/- a*b per lane, variable ready and latency
  logic [VW-1:0] fres;
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] pr;
      pr = fma_a[l*EW +: EW] * fma_b[l*EW +: EW];
      fres[l*EW +: EW] = fma_c[l*EW +: EW] + (fma_neg ? -pr : pr);
    end
  end
  int cyc = 0;
  int cnt = 0;
  int lat = 1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    fma_req_ready <= (cyc % 3) != 0;
    if (fma_req_valid && fma_req_ready) begin
      fma_rsp_data  <= fres;
      cnt           <= lat;
      lat           <= (lat % 3) + 1;
      fma_rsp_valid <= 1'b0;
    end else if (cnt != 0) begin
      cnt           <= cnt - 1;
      fma_rsp_valid <= (cnt == 1);
    end else begin
      fma_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  logic wb_seen = 1'b0;
  logic hold_prev = 1'b0;
  logic [VW-1:0] b_prev = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev)
        chk(fma_req_valid && fma_b == b_prev, "R10 request held", VW'(fma_req_valid), VW'(1));
      hold_prev = fma_req_valid && !fma_req_ready;
      b_prev = fma_b;
      if (rf_rd_en) begin
        if (exp_idx.size() == 0) chk(1'b0, "R12 unexpected register read", VW'(rf_rd_idx), '0);
        else begin
          logic [4:0] e;
          e = exp_idx.pop_front();
          chk(rf_rd_idx == e, "R2 register index", VW'(rf_rd_idx), VW'(e));
        end
      end
      if (mem_rd_en) begin
        if (exp_addr.size() == 0) chk(1'b0, "R12 unexpected memory read", VW'(mem_rd_addr), '0);
        else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          chk(mem_rd_addr == e, "R3 memory address", VW'(mem_rd_addr), VW'(e));
        end
      end
      if (fma_req_valid && fma_req_ready) begin
        chk(fma_b == {LANES{fma_b[EW-1:0]}}, "R4 broadcast lanes", fma_b, {LANES{fma_b[EW-1:0]}});
        chk(fma_neg == cur_neg, "R5 negate flag", VW'(fma_neg), VW'(cur_neg));
        chk(fma_lane_en == (cur_sc ? 16'h0001 : 16'hffff), "R9 lane enable",
            VW'(fma_lane_en), VW'(cur_sc ? 16'h0001 : 16'hffff));
      end
      if (wb_seen) chk(done && !wb_en && !busy, "R11 done after write-back", VW'({done, wb_en, busy}), VW'(3'b100));
      else if (done) chk(1'b0, "R11 done without write-back", VW'(done), '0);
      wb_seen = wb_en;
      if (wb_en) begin
        if (exp_wb.size() == 0) chk(1'b0, "R12 unexpected write-back", wb_data, '0);
        else begin
          logic [VW-1:0] e;
          e = exp_wb.pop_front();
          chk(wb_data == e, "R6 R7 R8 R9 written vector", wb_data, e);
        end
      end
    end
  end

  function automatic logic [VW-1:0] expect_wb(input logic [4:0] b, input logic [31:0] ma, input logic ng,
      input logic sc, input logic zm, input logic [15:0] mk, input logic [VW-1:0] dst);
    logic [VW-1:0] acc, r;
    acc = dst;
    for (int p = 0; p < 4; p++) begin
      logic [4:0] ix;
      logic [31:0] m;
      ix = {b[4:2], 2'(b[1:0] + 2'(p))};
      m  = mpat(ma + 32'(4 * p));
      for (int l = 0; l < LANES; l++) begin
        logic [31:0] pr;
        pr = rpat(ix, l) * m;
        if (!sc || l == 0) acc[l*EW +: EW] = acc[l*EW +: EW] + (ng ? -pr : pr);
      end
    end
    for (int l = 0; l < LANES; l++) begin
      if (sc && l >= 4)      r[l*EW +: EW] = '0;
      else if (sc && l >= 1) r[l*EW +: EW] = dst[l*EW +: EW];
      else if (mk[l])        r[l*EW +: EW] = acc[l*EW +: EW];
      else                   r[l*EW +: EW] = zm ? '0 : dst[l*EW +: EW];
    end
    return r;
  endfunction

  task automatic run_op(input logic [4:0] b, input logic [31:0] ma, input logic ng, input logic sc,
                        input logic zm, input logic [15:0] mk, input int seed, input bit poke_busy);
    logic [VW-1:0] dst;
    for (int l = 0; l < LANES; l++) dst[l*EW +: EW] = 32'h1000_0000 + 32'(seed * 16 + l);
    for (int p = 0; p < 4; p++) begin
      exp_idx.push_back({b[4:2], 2'(b[1:0] + 2'(p))});
      exp_addr.push_back(ma + 32'(4 * p));
    end
    exp_wb.push_back(expect_wb(b, ma, ng, sc, zm, mk, dst));
    @(negedge clk);
    cur_neg = ng; cur_sc = sc;
    base_reg = b; mem_base = ma; negate = ng; scalar_mode = sc; zero_mode = zm;
    wmask = mk; dst_in = dst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      base_reg = 5'd20; mem_base = 32'h900; negate = ~ng; scalar_mode = ~sc;
      zero_mode = ~zm; wmask = ~mk; dst_in = '1; start = 1'b1;   // R12: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_idx.size() == 0 && exp_addr.size() == 0 && exp_wb.size() == 0,
        "R1 four passes and one write-back", VW'(exp_idx.size() + exp_addr.size() + exp_wb.size()), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !wb_en && !rf_rd_en && !mem_rd_en && !fma_req_valid,
        "reset state", VW'({busy, done, wb_en, rf_rd_en, mem_rd_en, fma_req_valid}), '0);
    run_op(5'd12, 32'h100, 1'b0, 1'b0, 1'b0, 16'hA5C3, 1, 1'b0);  // R7 merge, base 12
    run_op(5'd13, 32'h200, 1'b1, 1'b0, 1'b1, 16'h0F0F, 2, 1'b0);  // R8 zero, R5 negate, wrap 13..12
    run_op(5'd6,  32'h040, 1'b0, 1'b1, 1'b0, 16'h0001, 3, 1'b0);  // R9 scalar merge
    run_op(5'd7,  32'h0C0, 1'b1, 1'b1, 1'b1, 16'hFFFE, 4, 1'b0);  // R9 scalar zero, bit 0 clear
    run_op(5'd31, 32'h3F4, 1'b0, 1'b0, 1'b1, 16'hFFFF, 5, 1'b0);  // R6 all lanes written
    run_op(5'd0,  32'h000, 1'b1, 1'b0, 1'b0, 16'h0000, 6, 1'b0);  // R7 all lanes kept
    run_op(5'd18, 32'h520, 1'b0, 1'b0, 1'b0, 16'h3C3C, 7, 1'b1);  // R12 second start while busy
    run_op(5'd9,  32'h080, 1'b1, 1'b0, 1'b1, 16'h8001, 8, 1'b0);  // R10 varied ready and latency
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule